// File: doc/BRIEF.md
# Thread Monitor Entry Cache

This block speeds up the common case of thread monitor handling. It keeps the two monitors that the running thread entered most recently, each one tagged with the word-aligned address of its object and holding a nesting count. An enter or exit request whose address matches a held monitor only adjusts that count. Every other case is handed to a software trap handler through a single-cycle trap pulse that carries a cause code. These cases are a lookup miss, a taken lock, a counter at its limit, and a release that finds a waiting thread.

The two lowest bits of an object header hold the lock flag (bit 0) and the waiter flag (bit 1). When an entry moves from count 0 to 1, the block tests the lock flag in the header word supplied with the request. When the count falls from 1 to 0, the block clears the lock flag. In both cases it returns the updated header word together with a write strobe. The caller performs the memory access. A separate pointer view path returns any header with both flag bits cleared, so that ordinary accesses see a word-aligned pointer. The trap handler fills and evicts entries through a software write port. The hardware never chooses a victim.

All responses are registered. A request presented at one clock edge is answered in the cycle after that edge.

Top module: `mon_cache`

## Requirements
- R1: After reset, no entry is valid, so an enter to any address traps with cause 2'b01. All response outputs are 0.
- R2: An enter that hits an entry whose count lies between 1 and 254 raises that count by one and pulses `done_o`. It does not write the header.
- R3: An enter that hits an entry with count 0 and a header whose bit 0 is clear sets the count to 1 and pulses `done_o`. It also pulses `hdr_we_o`, and `hdr_out_o` equals the input header with bit 0 set.
- R4: An enter that hits an entry with count 0 and a header whose bit 0 is set pulses a trap with cause 2'b10. The count stays 0.
- R5: An exit that hits an entry with count 2 or more lowers that count by one and pulses `done_o`.
- R6: An exit that hits an entry with count 1 sets the count to 0 and writes the header back with bit 0 cleared. It pulses `done_o` when header bit 1 is clear. It pulses a trap with cause 2'b11 when header bit 1 is set.
- R7: A request whose address bits [31:2] match no valid entry traps with cause 2'b01. An exit that hits an entry with count 0 also traps with cause 2'b01. Address bits [1:0] never affect matching.
- R8: An enter that hits an entry with count 255 traps with cause 2'b01 and leaves the count at 255.
- R9: Responses appear in the cycle after the request edge. `done_o` and `trap_o` are never high together. `cause_o` is 2'b00 whenever `trap_o` is low. A cycle with no request gives no response in the next cycle.
- R10: A software write with `sw_install` high loads the selected slot with an address and a count and marks it valid. With `sw_install` low the write invalidates the slot. A request in the same cycle as a software write is ignored.
- R11: `view_out_o` equals the previous cycle's `view_in` with bits [1:0] forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Monitor request strobe |
| req_exit | input | 1 | 1 = exit, 0 = enter |
| req_addr | input | ADDR_W | Object address; bits [1:0] ignored |
| hdr_in | input | ADDR_W | Current object header word |
| view_in | input | ADDR_W | Header word for a plain (non-monitor) access |
| sw_we | input | 1 | Software slot write strobe |
| sw_slot | input | SEL_W | Slot selected by the software write |
| sw_install | input | 1 | 1 = install, 0 = invalidate |
| sw_addr | input | ADDR_W | Address loaded on install |
| sw_cnt | input | CNT_W | Count loaded on install |
| done_o | output | 1 | Request completed in hardware |
| trap_o | output | 1 | Trap request pulse |
| cause_o | output | 2 | Trap cause: 01 miss/limit, 10 contention, 11 waiter |
| hdr_we_o | output | 1 | Updated header must be written back |
| hdr_out_o | output | ADDR_W | Updated header word |
| view_out_o | output | ADDR_W | Header with flag bits cleared |

## Verification
The assertions take it as given that software never installs the same address in both slots. They also assume that `hdr_in` belongs to the object named by `req_addr`, and that inputs are held stable around the clock edge. The stimulus respects these assumptions: slot 0 only ever receives addresses from one pool, slot 1 only from a disjoint pool, and all inputs change on the falling edge. Within those limits, the random phase mixes installs, invalidates, enters and exits. It uses counts near 0 and near 255 and all four combinations of the header flags. Collisions between a software write and a request are also exercised.

// File: rtl/mon_pkg.sv
package mon_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_MISS   = 2'b01,
    CAUSE_BUSY   = 2'b10,
    CAUSE_WAITER = 2'b11
  } cause_e;

  localparam int LOCK_BIT = 0;
  localparam int WANT_BIT = 1;
  localparam int FLAG_W   = 2;
endpackage

// File: rtl/mon_slot.sv
module mon_slot #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  logic              sw_install,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [CNT_W-1:0]  sw_cnt,
  input  logic              upd_en,
  input  logic [CNT_W-1:0]  upd_cnt,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              match_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      cnt_q   <= '0;
    end else if (sw_we) begin
      valid_q <= sw_install;
      if (sw_install) begin
        addr_q <= sw_addr;
        cnt_q  <= sw_cnt;
      end
    end else if (upd_en) begin
      cnt_q <= upd_cnt;
    end
  end

  assign match_o = valid_q && (addr_q == look_addr);
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/mon_pick.sv
module mon_pick #(
  parameter int N_SLOTS = 2,
  parameter int CNT_W   = 8,
  parameter int SEL_W   = 1
) (
  input  logic [N_SLOTS-1:0]       match,
  input  logic [N_SLOTS*CNT_W-1:0] cnts,
  output logic                     hit_any,
  output logic [SEL_W-1:0]         hit_idx,
  output logic [CNT_W-1:0]         hit_cnt
);
  always_comb begin
    hit_any = |match;
    hit_idx = '0;
    hit_cnt = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_idx = SEL_W'(i);
        hit_cnt = cnts[i*CNT_W +: CNT_W];
      end
    end
  end
endmodule

// File: rtl/mon_ctrl.sv
module mon_ctrl
  import mon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              go,
  input  logic              is_exit,
  input  logic              hit_any,
  input  logic [CNT_W-1:0]  hit_cnt,
  input  logic [ADDR_W-1:0] hdr_in,
  output logic              upd_en,
  output logic [CNT_W-1:0]  upd_cnt,
  output logic              done,
  output logic              trap,
  output cause_e            cause,
  output logic              hdr_we,
  output logic [ADDR_W-1:0] hdr_val
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_comb begin
    upd_en  = 1'b0;
    upd_cnt = hit_cnt;
    done    = 1'b0;
    trap    = 1'b0;
    cause   = CAUSE_NONE;
    hdr_we  = 1'b0;
    hdr_val = hdr_in;
    if (go) begin
      if (!hit_any) begin
        trap  = 1'b1;
        cause = CAUSE_MISS;
      end else if (!is_exit) begin
        if (hit_cnt == '0) begin
          if (hdr_in[LOCK_BIT]) begin
            trap  = 1'b1;
            cause = CAUSE_BUSY;
          end else begin
            upd_en            = 1'b1;
            upd_cnt           = CNT_ONE;
            hdr_we            = 1'b1;
            hdr_val[LOCK_BIT] = 1'b1;
            done              = 1'b1;
          end
        end else if (hit_cnt == CNT_MAX) begin
          trap  = 1'b1;
          cause = CAUSE_MISS;
        end else begin
          upd_en  = 1'b1;
          upd_cnt = hit_cnt + CNT_ONE;
          done    = 1'b1;
        end
      end else begin
        if (hit_cnt == '0) begin
          trap  = 1'b1;
          cause = CAUSE_MISS;
        end else begin
          upd_en  = 1'b1;
          upd_cnt = hit_cnt - CNT_ONE;
          if (hit_cnt == CNT_ONE) begin
            hdr_we            = 1'b1;
            hdr_val[LOCK_BIT] = 1'b0;
            if (hdr_in[WANT_BIT]) begin
              trap  = 1'b1;
              cause = CAUSE_WAITER;
            end else begin
              done = 1'b1;
            end
          end else begin
            done = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mon_cache.sv
module mon_cache
  import mon_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 8,
  parameter int N_SLOTS = 2,
  localparam int SEL_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_exit,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] hdr_in,
  input  logic [ADDR_W-1:0] view_in,
  input  logic              sw_we,
  input  logic [SEL_W-1:0]  sw_slot,
  input  logic              sw_install,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [CNT_W-1:0]  sw_cnt,
  output logic              done_o,
  output logic              trap_o,
  output logic [1:0]        cause_o,
  output logic              hdr_we_o,
  output logic [ADDR_W-1:0] hdr_out_o,
  output logic [ADDR_W-1:0] view_out_o
);
  localparam logic [ADDR_W-1:0] FLAG_MASK = ADDR_W'((1 << FLAG_W) - 1);

  logic [ADDR_W-1:0]        look_addr;
  logic [ADDR_W-1:0]        inst_addr;
  logic [N_SLOTS-1:0]       match;
  logic [N_SLOTS*CNT_W-1:0] cnts;
  logic                     hit_any;
  logic [SEL_W-1:0]         hit_idx;
  logic [CNT_W-1:0]         hit_cnt;
  logic                     go;
  logic                     upd_en;
  logic [CNT_W-1:0]         upd_cnt;
  logic                     c_done;
  logic                     c_trap;
  cause_e                   c_cause;
  logic                     c_hdr_we;
  logic [ADDR_W-1:0]        c_hdr_val;

  assign look_addr = req_addr & ~FLAG_MASK;
  assign inst_addr = sw_addr & ~FLAG_MASK;
  assign go        = req_valid && !sw_we;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    logic slot_sw_we;
    logic slot_upd;
    assign slot_sw_we = sw_we && (sw_slot == SEL_W'(g));
    assign slot_upd   = upd_en && (hit_idx == SEL_W'(g));
    mon_slot #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .sw_we      (slot_sw_we),
      .sw_install (sw_install),
      .sw_addr    (inst_addr),
      .sw_cnt     (sw_cnt),
      .upd_en     (slot_upd),
      .upd_cnt    (upd_cnt),
      .look_addr  (look_addr),
      .match_o    (match[g]),
      .cnt_o      (cnts[g*CNT_W +: CNT_W])
    );
  end

  mon_pick #(.N_SLOTS(N_SLOTS), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_pick (
    .match   (match),
    .cnts    (cnts),
    .hit_any (hit_any),
    .hit_idx (hit_idx),
    .hit_cnt (hit_cnt)
  );

  mon_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .go      (go),
    .is_exit (req_exit),
    .hit_any (hit_any),
    .hit_cnt (hit_cnt),
    .hdr_in  (hdr_in),
    .upd_en  (upd_en),
    .upd_cnt (upd_cnt),
    .done    (c_done),
    .trap    (c_trap),
    .cause   (c_cause),
    .hdr_we  (c_hdr_we),
    .hdr_val (c_hdr_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o     <= 1'b0;
      trap_o     <= 1'b0;
      cause_o    <= 2'b00;
      hdr_we_o   <= 1'b0;
      hdr_out_o  <= '0;
      view_out_o <= '0;
    end else begin
      done_o     <= c_done;
      trap_o     <= c_trap;
      cause_o    <= c_cause;
      hdr_we_o   <= c_hdr_we;
      hdr_out_o  <= c_hdr_val;
      view_out_o <= view_in & ~FLAG_MASK;
    end
  end
endmodule

// File: rtl/mon_cache_chk.sv
module mon_cache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_exit,
  input logic [ADDR_W-1:0] hdr_in,
  input logic              sw_we,
  input logic              done_o,
  input logic              trap_o,
  input logic [1:0]        cause_o,
  input logic              hdr_we_o,
  input logic [ADDR_W-1:0] hdr_out_o,
  input logic [ADDR_W-1:0] view_out_o
);
  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst) !(done_o && trap_o)); // R9
  AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (rst) !trap_o |-> cause_o == 2'b00); // R9
  AST_TRAP_CODED: assert property (@(posedge clk) disable iff (rst) trap_o |-> cause_o != 2'b00); // R9
  AST_QUIET_NO_REQ: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !done_o && !trap_o && !hdr_we_o); // R9
  AST_SW_BLOCKS: assert property (@(posedge clk) disable iff (rst) sw_we |=> !done_o && !trap_o && !hdr_we_o); // R10
  AST_LOCK_SET: assert property (@(posedge clk) disable iff (rst) hdr_we_o && !$past(req_exit) |-> hdr_out_o[0]); // R3
  AST_LOCK_CLEAR: assert property (@(posedge clk) disable iff (rst) hdr_we_o && $past(req_exit) |-> !hdr_out_o[0]); // R6
  AST_HDR_KEEP: assert property (@(posedge clk) disable iff (rst) hdr_we_o |-> hdr_out_o[ADDR_W-1:1] == $past(hdr_in[ADDR_W-1:1])); // R6
  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (rst) trap_o && cause_o == 2'b10 |-> $past(hdr_in[0]) && !$past(req_exit) && !hdr_we_o); // R4
  AST_WAITER_CAUSE: assert property (@(posedge clk) disable iff (rst) trap_o && cause_o == 2'b11 |-> $past(hdr_in[1]) && $past(req_exit) && hdr_we_o); // R6
  AST_VIEW_ALIGNED: assert property (@(posedge clk) disable iff (rst) view_out_o[1:0] == 2'b00); // R11
endmodule

bind mon_cache mon_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_exit   (req_exit),
  .hdr_in     (hdr_in),
  .sw_we      (sw_we),
  .done_o     (done_o),
  .trap_o     (trap_o),
  .cause_o    (cause_o),
  .hdr_we_o   (hdr_we_o),
  .hdr_out_o  (hdr_out_o),
  .view_out_o (view_out_o)
);

// File: tb/mon_cache_bench.sv
`timescale 1ns/1ps
module mon_cache_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_exit = 1'b0;
  logic [31:0] req_addr = '0, hdr_in = '0, view_in = '0;
  logic        sw_we = 1'b0, sw_install = 1'b0;
  logic [0:0]  sw_slot = '0;
  logic [31:0] sw_addr = '0;
  logic [7:0]  sw_cnt = '0;
  logic        done_o, trap_o, hdr_we_o;
  logic [1:0]  cause_o;
  logic [31:0] hdr_out_o, view_out_o;

  int checks = 0;
  int failures = 0;

  // behavioural reference state
  bit          m_valid [2];
  logic [31:0] m_addr  [2];
  int          m_cnt   [2];

  logic        e_done, e_trap, e_hw;
  logic [1:0]  e_cause;
  logic [31:0] e_hdr, e_view;

  localparam logic [31:0] A0 = 32'h0000_1000, A1 = 32'h0000_2000;
  localparam logic [31:0] B0 = 32'h0000_3000, B1 = 32'h0000_4000;

  always #10 clk = ~clk;

  mon_cache u_mon_cache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_exit(req_exit),
    .req_addr(req_addr), .hdr_in(hdr_in), .view_in(view_in),
    .sw_we(sw_we), .sw_slot(sw_slot), .sw_install(sw_install),
    .sw_addr(sw_addr), .sw_cnt(sw_cnt),
    .done_o(done_o), .trap_o(trap_o), .cause_o(cause_o),
    .hdr_we_o(hdr_we_o), .hdr_out_o(hdr_out_o), .view_out_o(view_out_o)
  );

  task automatic model();
    int h;
    e_done = 0; e_trap = 0; e_cause = 2'b00; e_hw = 0; e_hdr = '0;
    e_view = {view_in[31:2], 2'b00};
    if (sw_we) begin
      m_valid[sw_slot] = sw_install;
      if (sw_install) begin
        m_addr[sw_slot] = {sw_addr[31:2], 2'b00};
        m_cnt[sw_slot]  = sw_cnt;
      end
    end else if (req_valid) begin
      h = -1;
      for (int i = 1; i >= 0; i--)
        if (m_valid[i] && m_addr[i] == {req_addr[31:2], 2'b00}) h = i;
      if (h < 0) begin
        e_trap = 1; e_cause = 2'b01;
      end else if (!req_exit) begin
        if (m_cnt[h] == 0) begin
          if (hdr_in[0]) begin e_trap = 1; e_cause = 2'b10; end
          else begin m_cnt[h] = 1; e_done = 1; e_hw = 1; e_hdr = hdr_in | 32'h1; end
        end else if (m_cnt[h] == 255) begin
          e_trap = 1; e_cause = 2'b01;
        end else begin
          m_cnt[h]++; e_done = 1;
        end
      end else begin
        if (m_cnt[h] == 0) begin
          e_trap = 1; e_cause = 2'b01;
        end else begin
          m_cnt[h]--;
          if (m_cnt[h] == 0) begin
            e_hw = 1; e_hdr = hdr_in & ~32'h1;
            if (hdr_in[1]) begin e_trap = 1; e_cause = 2'b11; end
            else e_done = 1;
          end else e_done = 1;
        end
      end
    end
  endtask

  // drive at falling edge, compare at the next falling edge
  task automatic tick(input string tag);
    logic [68:0] act, exp;
    model();
    @(posedge clk);
    @(negedge clk);
    act = {done_o, trap_o, cause_o, hdr_we_o, (hdr_we_o ? hdr_out_o : 32'h0), view_out_o};
    exp = {e_done, e_trap, e_cause, e_hw, e_hdr, e_view};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
    req_valid = 0; sw_we = 0;
  endtask

  task automatic req(input string tag, input logic ex, input logic [31:0] a, input logic [31:0] h);
    req_valid = 1; req_exit = ex; req_addr = a; hdr_in = h;
    tick(tag);
  endtask

  task automatic sw(input string tag, input int s, input logic ins, input logic [31:0] a, input int c);
    sw_we = 1; sw_slot = 1'(s); sw_install = ins; sw_addr = a; sw_cnt = 8'(c);
    tick(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin m_valid[i] = 0; m_addr[i] = '0; m_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    checks++;
    if ({done_o, trap_o, cause_o, hdr_we_o, hdr_out_o, view_out_o} !== '0) begin
      failures++;
      $display("FAIL R1 reset outputs actual=%b%b%b%b expected=0", done_o, trap_o, cause_o, hdr_we_o);
    end
    req("R1 miss after reset", 0, A0, 32'h0);
    sw("R10 install slot0", 0, 1, A0, 0);
    req("R3 first entry lock free", 0, A0 | 32'h3, 32'hABCD_0000);
    req("R2 reentry", 0, A0, 32'h0);
    req("R2 reentry", 0, A0 | 32'h2, 32'h0);
    req("R5 exit nested", 1, A0, 32'h0);
    req("R5 exit nested", 1, A0, 32'h0);
    req("R6 release no waiter", 1, A0, 32'h5555_0001);
    req("R7 exit at zero", 1, A0, 32'h0);
    req("R3 reacquire", 0, A0, 32'h1234_5672);
    req("R6 release with waiter", 1, A0, 32'h1234_5673);
    sw("R10 install slot1", 1, 1, B0, 0);
    req("R4 contention", 0, B0, 32'h0000_8001);
    req("R4 count unchanged", 1, B0, 32'h0);
    sw("R10 install slot1 full", 1, 1, B1, 255);
    req("R8 count limit", 0, B1, 32'h0);
    req("R8 count kept", 1, B1, 32'h0);
    req("R7 miss other address", 0, A1, 32'h0);
    sw("R10 invalidate slot0", 0, 0, A0, 0);
    req("R10 evicted misses", 0, A0, 32'h0);
    req_valid = 1; req_exit = 0; req_addr = B1; hdr_in = 32'h0;
    sw("R10 request ignored during write", 0, 1, A1, 3);
    req("R10 slot1 untouched", 1, B1, 32'h0);
    req("R2 installed count", 0, A1, 32'h0);
    view_in = 32'hDEAD_BEEF;
    tick("R11 plain view");
    view_in = 32'h0000_0003;
    tick("R9 idle");
    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(0, 9);
      view_in = $urandom;
      if (r < 2) begin
        int s = $urandom_range(0, 1);
        int cs[6] = '{0, 1, 2, 254, 255, 7};
        logic [31:0] a = (s == 0) ? (($urandom_range(0, 1) == 1) ? A0 : A1)
                                  : (($urandom_range(0, 1) == 1) ? B0 : B1);
        if ($urandom_range(0, 1) == 1) req_valid = 1;
        sw("R10 random write", s, ($urandom_range(0, 4) != 0), a, cs[$urandom_range(0, 5)]);
      end else if (r < 9) begin
        logic [31:0] pool[5] = '{A0, A1, B0, B1, 32'h0000_5000};
        req("R9 random request", 1'($urandom_range(0, 1)),
            pool[$urandom_range(0, 4)] | 32'($urandom_range(0, 3)),
            ($urandom & 32'hFFFF_FFFC) | 32'($urandom_range(0, 3)));
      end else begin
        tick("R9 random idle");
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule